// File: doc/BRIEF.md
# Video Capture DMA Program Sequencer

The sequencer moves captured video bytes into memory under control of a small program that also lives in memory. Each instruction is a 64-bit pair: a control word and an address word. The sequencer fetches one pair at a time through a read request/response port. It then carries out the instruction:

- wait for the start of an odd or an even field;
- jump to a new program address;
- copy a run of pixel bytes from the incoming byte stream into memory, as 32-bit word writes that each carry a byte count.

One scan line can be spread over several scattered memory fragments. A line-start instruction opens the line on the stream's start-of-line marker. Continuation instructions then take further bytes of the same line and send them to their own addresses. A byte-position field lets any data instruction skip the leading bytes it does not want. Any instruction can raise a one-cycle interrupt when it completes. A malformed control word stops the engine and leaves an error flag set until reset.

The driver builds the program, loads its address onto `prog_base` and pulses `go`. A program that ends with a jump back to its own start runs without further attention.

Top module: `vcap_seq`

## Requirements
- R1: After reset the sequencer is idle. `ifr_req`, `wr_valid`, `irq` and `err` are low, and `px_ready` is high, so stream bytes are dropped. A `go` pulse sets the program counter to `prog_base` with its low three bits cleared, and the first fetch goes to that address.
- R2: A fetch reads the pair at the program counter, which is always 8-byte aligned. The response `ifr_rdata` carries the control word in bits 31:0 and the address word in bits 63:32. Every instruction other than a jump advances the counter by 8 when it completes.
- R3: A control word with bit 31 clear, or with an opcode in bits 30:28 outside 1..5, halts the sequencer. `err` then rises and stays high until reset, and no further fetch or write request is made.
- R4: Opcode 1 waits for the next `fld_start` pulse with `fld_odd` = 1, and opcode 2 waits for the next pulse with `fld_odd` = 0. Pulses of the other parity are ignored. Stream bytes that arrive during the wait are dropped, and the address word has no effect.
- R5: Opcode 3 loads the program counter from bits 31:3 of its address word.
- R6: Opcode 4 (line-start) drops stream bytes until one arrives with `px_sol` high. That byte is line position 0, and later bytes take consecutive positions.
- R7: Opcode 5 (continue) carries on from the line position where the previous data instruction stopped, and does not wait for `px_sol`.
- R8: A data instruction drops bytes whose line position is below its start field, held in control bits 23:12. The count field in bits 11:0 gives the number of bytes it keeps. Control bits 26:24 have no effect.
- R9: Kept bytes are packed little-endian into 32-bit beats. Each instruction starts a new beat at word address `addr[31:2]`, and each later beat goes to the next word address. `wr_cnt` gives the number of valid bytes in the beat (1 to 4), and unused byte lanes read as zero.
- R10: A data instruction completes when its last beat has been accepted. With a count of 0 it completes without taking a byte. Bytes of the line beyond its counts stay in the stream, and the next line-start or sync drops them.
- R11: Control bit 27 makes the sequencer pulse `irq` high for exactly one cycle when that instruction completes.
- R12: `ifr_req`/`ifr_addr` and `wr_valid`/`wr_addr`/`wr_data`/`wr_cnt` stay unchanged until they are accepted. `px_ready` is low while a fetch is in flight and while a write beat is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse, taken only while idle |
| prog_base | input | 32 | Byte address of the first instruction |
| ifr_req | output | 1 | Instruction fetch request |
| ifr_addr | output | 32 | Byte address of the instruction pair |
| ifr_gnt | input | 1 | Fetch request accepted |
| ifr_rvalid | input | 1 | Fetch response valid |
| ifr_rdata | input | 64 | {address word, control word} |
| fld_start | input | 1 | Field start pulse |
| fld_odd | input | 1 | Parity of the starting field (1 = odd) |
| px_valid | input | 1 | Stream byte valid |
| px_sol | input | 1 | Byte is the first of a scan line |
| px_data | input | 8 | Stream byte |
| px_ready | output | 1 | Stream byte taken |
| wr_valid | output | 1 | Write beat valid |
| wr_addr | output | 30 | 32-bit word address of the beat |
| wr_data | output | 32 | Little-endian packed bytes |
| wr_cnt | output | 3 | Valid bytes in the beat, 1 to 4 |
| wr_ready | input | 1 | Write beat accepted |
| irq | output | 1 | One-cycle completion interrupt |
| err | output | 1 | Sticky invalid-instruction flag |

## Verification
Timing follows from the handshakes rather than from fixed offsets:

- **Fetch decode:** a fetch response is decoded at the edge where `ifr_rvalid` is high. A halt therefore shows up on `err` one cycle after a bad response, and a jump's new address appears on `ifr_addr` in the next cycle.
- **Write beats:** a beat appears one cycle after its last byte is taken.
- **Completion interrupt:** `irq` rises one cycle after the final beat is accepted, or after the matching field pulse.

The bench's memory, stream and write models use deliberate stalls and latency. Because of that, checks never sample at a fixed cycle. Each check waits, with a bound, for the transaction count it needs, then compares the logged beats, fetch addresses and interrupt pulses (counted one per cycle high) at a falling edge.

// File: rtl/vcap_seq.sv
module vcap_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [31:0] prog_base,
  output logic        ifr_req,
  output logic [31:0] ifr_addr,
  input  logic        ifr_gnt,
  input  logic        ifr_rvalid,
  input  logic [63:0] ifr_rdata,
  input  logic        fld_start,
  input  logic        fld_odd,
  input  logic        px_valid,
  input  logic        px_sol,
  input  logic [7:0]  px_data,
  output logic        px_ready,
  output logic        wr_valid,
  output logic [29:0] wr_addr,
  output logic [31:0] wr_data,
  output logic [2:0]  wr_cnt,
  input  logic        wr_ready,
  output logic        irq,
  output logic        err
);
  localparam int CW = 12;
  localparam logic [2:0] OP_SYO = 3'd1, OP_SYE = 3'd2, OP_JMP = 3'd3,
                         OP_LS  = 3'd4, OP_INL = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_FREQ, S_FRSP, S_SYNC, S_DATA, S_HALT} st_t;

  st_t          st;
  logic [28:0]  pc;
  logic         op_ls, armed, want_odd, irq_en, wr_v, irq_r, err_r;
  logic [CW-1:0] start, rem, pos;
  logic [29:0]  waddr;
  logic [2:0]   lane;
  logic [31:0]  pack;

  wire [31:0] cw = ifr_rdata[31:0];
  wire [31:0] aw = ifr_rdata[63:32];
  wire [2:0]  op = cw[30:28];
  wire        op_ok = cw[31] && op >= OP_SYO && op <= OP_INL;
  wire [CW-1:0] cnt_f = cw[CW-1:0];

  logic unused_bits;
  assign unused_bits = ^{cw[26:24], aw[1:0], prog_base[2:0]};

  wire          first  = op_ls && !armed;
  wire          take   = (st == S_DATA) && px_valid && px_ready;
  wire [CW-1:0] bp     = first ? '0 : pos;
  wire          usable = !(first && !px_sol);
  wire          keep   = take && usable && (bp >= start);
  wire [2:0]    lane_n = lane + 3'd1;
  wire [CW-1:0] rem_n  = rem - 1'b1;
  wire          beat_done = wr_v && wr_ready;

  assign ifr_req  = (st == S_FREQ);
  assign ifr_addr = {pc, 3'b000};
  assign px_ready = (st == S_IDLE) || (st == S_SYNC) || (st == S_HALT) ||
                    ((st == S_DATA) && !wr_v && (rem != '0));
  assign wr_valid = wr_v;
  assign wr_addr  = waddr;
  assign wr_data  = pack;
  assign wr_cnt   = lane;
  assign irq      = irq_r;
  assign err      = err_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; pc <= '0; op_ls <= 1'b0; armed <= 1'b0; want_odd <= 1'b0;
      irq_en <= 1'b0; wr_v <= 1'b0; irq_r <= 1'b0; err_r <= 1'b0;
      start <= '0; rem <= '0; pos <= '0; waddr <= '0; lane <= '0; pack <= '0;
    end else begin
      irq_r <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          pc <= prog_base[31:3];
          st <= S_FREQ;
        end
        S_FREQ: if (ifr_gnt) st <= S_FRSP;
        S_FRSP: if (ifr_rvalid) begin
          if (!op_ok) begin
            st    <= S_HALT;
            err_r <= 1'b1;
          end else if (op == OP_SYO || op == OP_SYE) begin
            want_odd <= (op == OP_SYO);
            irq_en   <= cw[27];
            st       <= S_SYNC;
          end else if (op == OP_JMP) begin
            pc    <= aw[31:3];
            irq_r <= cw[27];
            st    <= S_FREQ;
          end else begin
            op_ls  <= (op == OP_LS);
            armed  <= 1'b0;
            start  <= cw[23:12];
            rem    <= cnt_f;
            waddr  <= aw[31:2];
            lane   <= '0;
            pack   <= '0;
            irq_en <= cw[27];
            if (cnt_f == '0) begin
              irq_r <= cw[27];
              pc    <= pc + 29'd1;
              st    <= S_FREQ;
            end else begin
              st <= S_DATA;
            end
          end
        end
        S_SYNC: if (fld_start && (fld_odd == want_odd)) begin
          irq_r <= irq_en;
          pc    <= pc + 29'd1;
          st    <= S_FREQ;
        end
        S_DATA: begin
          if (take && usable) begin
            pos   <= bp + 1'b1;
            armed <= 1'b1;
          end
          if (keep) begin
            pack[lane[1:0]*8 +: 8] <= px_data;
            lane <= lane_n;
            rem  <= rem_n;
            if (lane_n == 3'd4 || rem_n == '0) wr_v <= 1'b1;
          end
          if (beat_done) begin
            wr_v  <= 1'b0;
            waddr <= waddr + 30'd1;
            lane  <= '0;
            pack  <= '0;
            if (rem == '0) begin
              irq_r <= irq_en;
              pc    <= pc + 29'd1;
              st    <= S_FREQ;
            end
          end
        end
        S_HALT: st <= S_HALT;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vcap_seq_chk.sv
module vcap_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ifr_req,
  input logic        ifr_gnt,
  input logic [31:0] ifr_addr,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [29:0] wr_addr,
  input logic [31:0] wr_data,
  input logic [2:0]  wr_cnt,
  input logic        px_ready,
  input logic        irq,
  input logic        err
);
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ifr_req && !ifr_gnt |=> ifr_req && $stable(ifr_addr)); // R12
  AST_FETCH_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    ifr_req |-> ifr_addr[2:0] == 3'b000); // R2
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_cnt)); // R12
  AST_WR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_cnt >= 3'd1 && wr_cnt <= 3'd4); // R9
  AST_WR_STALLS_PX: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !px_ready); // R12
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R3
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !ifr_req && !wr_valid); // R3
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R11
endmodule

bind vcap_seq vcap_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ifr_req(ifr_req), .ifr_gnt(ifr_gnt), .ifr_addr(ifr_addr),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_cnt(wr_cnt), .px_ready(px_ready), .irq(irq), .err(err)
);

// File: tb/tb_vcap_seq.sv
module tb_vcap_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic [31:0] prog_base = '0;
  logic ifr_req, ifr_gnt, ifr_rvalid;
  logic [31:0] ifr_addr;
  logic [63:0] ifr_rdata;
  logic fld_start, fld_odd, px_valid, px_sol, px_ready;
  logic [7:0] px_data;
  logic wr_valid, wr_ready, irq, err;
  logic [29:0] wr_addr;
  logic [31:0] wr_data;
  logic [2:0] wr_cnt;

  always #2 clk = ~clk;

  vcap_seq dut (
    .clk(clk), .rst_n(rst_n), .go(go), .prog_base(prog_base),
    .ifr_req(ifr_req), .ifr_addr(ifr_addr), .ifr_gnt(ifr_gnt),
    .ifr_rvalid(ifr_rvalid), .ifr_rdata(ifr_rdata),
    .fld_start(fld_start), .fld_odd(fld_odd),
    .px_valid(px_valid), .px_sol(px_sol), .px_data(px_data), .px_ready(px_ready),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_cnt(wr_cnt),
    .wr_ready(wr_ready), .irq(irq), .err(err)
  );

  // expected beats {word address, data, count}
  localparam logic [64:0] EXP [0:11] = '{
    {30'h400,  32'h03020100, 3'd4},  // R6 line opens on marker
    {30'h401,  32'h07060504, 3'd4},
    {30'h402,  32'h0B0A0908, 3'd4},
    {30'h800,  32'h13121110, 3'd4},
    {30'h801,  32'h00001514, 3'd2},  // R9 partial beat, zero lanes
    {30'hC00,  32'h19181716, 3'd4},  // R7 continuation keeps position
    {30'h1000, 32'h25242322, 3'd4},  // R8 start field skips 2 bytes
    {30'h1001, 32'h00000026, 3'd1},
    {30'h1400, 32'h002B2A29, 3'd3},  // R8 continuation skips to 9
    {30'h1800, 32'h33323130, 3'd4},  // R10 leftovers dropped
    {30'h1C00, 32'h43424140, 3'd4},  // R4 even field after odd junk line
    {30'h1C01, 32'h47464544, 3'd4}
  };

  logic [63:0] prog [0:31];
  logic [10:0] strm [0:127];
  int slen = 0;
  int sidx;
  logic src_en = 1'b0;
  logic [31:0] cyc;
  int nfetch, nwr, nirq;
  logic [31:0] first_fa, last_fa, faddr;
  int dly;
  logic [64:0] wlog [0:31];
  int checks = 0, fails = 0;

  wire in_rng = src_en && (sidx < slen);
  assign px_valid  = in_rng && !strm[sidx[6:0]][10];
  assign px_sol    = strm[sidx[6:0]][9];
  assign px_data   = strm[sidx[6:0]][7:0];
  assign fld_start = in_rng && strm[sidx[6:0]][10] && px_ready;
  assign fld_odd   = strm[sidx[6:0]][9];
  assign ifr_gnt   = cyc[0];
  assign wr_ready  = (cyc[1:0] != 2'b11);

  always @(posedge clk) begin
    cyc <= (!rst_n) ? 32'd0 : cyc + 32'd1;
    if (!rst_n || !src_en) sidx <= 0;
    else if ((px_valid && px_ready) || fld_start) sidx <= sidx + 1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      dly <= 0; ifr_rvalid <= 1'b0; nfetch <= 0; nwr <= 0; nirq <= 0;
    end else begin
      ifr_rvalid <= 1'b0;
      if (dly != 0) begin
        dly <= dly - 1;
        if (dly == 1) begin
          ifr_rvalid <= 1'b1;
          ifr_rdata  <= prog[faddr[7:3]];
        end
      end
      if (ifr_req && ifr_gnt) begin
        faddr <= ifr_addr; dly <= 2; nfetch <= nfetch + 1; last_fa <= ifr_addr;
        if (nfetch == 0) first_fa <= ifr_addr;
      end
      if (wr_valid && wr_ready) begin
        if (nwr < 32) wlog[nwr] <= {wr_addr, wr_data, wr_cnt};
        nwr <= nwr + 1;
      end
      if (irq) nirq <= nirq + 1;
    end
  end

  task automatic chk(input string tag, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [10:0] v);
    strm[slen[6:0]] = v;
    slen++;
  endtask

  task automatic put_line(input logic [7:0] b);
    for (int p = 0; p < 12; p++) push({1'b0, p == 0, 1'b0, b + 8'(p)});
  endtask

  task automatic do_reset();
    src_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic start_prog(input logic [31:0] base);
    prog_base = base;
    go = 1'b1;
    src_en = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 32; i++) prog[i] = 64'h0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    clear_prog();
    prog[8]  = {32'h0000_0000, 32'h9000_0000};
    prog[9]  = {32'h0000_1000, 32'hC000_000C};
    prog[10] = {32'h0000_2000, 32'hC000_0006};
    prog[11] = {32'h0000_3000, 32'hD800_6004};
    prog[12] = {32'h0000_4000, 32'hC000_2005};
    prog[13] = {32'h0000_5000, 32'hD000_9003};
    prog[14] = {32'h0000_6000, 32'hC000_0004};
    prog[15] = {32'h0000_0000, 32'hA800_0000};
    prog[16] = {32'h0000_7000, 32'hC500_0008};
    prog[17] = {32'h0000_0040, 32'hB800_0000};
    push(11'h400); put_line(8'hE0); push(11'h600);
    put_line(8'h00); put_line(8'h10); put_line(8'h20); put_line(8'h30);
    push(11'h600); put_line(8'hD0); push(11'h400); put_line(8'h40);

    do_reset();
    chk("R1 reset outputs", {60'h0, ifr_req, wr_valid, irq, err, px_ready}, 65'h1);

    start_prog(32'h0000_0047);
    for (int t = 0; t < 4000; t++) begin
      if (nfetch >= 11) break;
      @(negedge clk);
    end
    repeat (30) @(negedge clk);

    for (int i = 0; i < 12; i++) chk("R9 write beat", wlog[i], EXP[i]);
    chk("R10 beat total", 65'(nwr), 65'd12);
    chk("R11 irq pulses", 65'(nirq), 65'd3);
    chk("R1 first fetch address", 65'(first_fa), 65'h40);
    chk("R2 fetch total", 65'(nfetch), 65'd11);
    chk("R5 jump target fetched", 65'(last_fa), 65'h40);
    chk("R3 no error on valid program", 65'(err), 65'd0);
    chk("R4 waiting for odd field", {64'h0, px_ready}, 65'd1);

    // invalid: bit 31 clear
    clear_prog();
    prog[0] = {32'h0000_1000, 32'h4000_000C};
    do_reset();
    start_prog(32'h0);
    repeat (40) @(negedge clk);
    chk("R3 clear valid bit halts", {nfetch[31:0], nwr[31:0], err}, {32'd1, 32'd0, 1'b1});

    // zero-count data op with irq, then bad opcode 7
    clear_prog();
    prog[0] = {32'h0000_1000, 32'hC800_0000};
    prog[1] = {32'h0000_0000, 32'hF000_0000};
    do_reset();
    start_prog(32'h0);
    repeat (60) @(negedge clk);
    chk("R10 zero count no write", 65'(nwr), 65'd0);
    chk("R11 zero count irq", 65'(nirq), 65'd1);
    chk("R3 opcode 7 halts", {nfetch[31:0], err}, {32'd2, 1'b1});
    chk("R3 halt drops stream", {64'h0, px_ready}, 65'd1);

    // opcode 0 with valid bit
    clear_prog();
    prog[0] = {32'h0000_0000, 32'h8000_0000};
    do_reset();
    start_prog(32'h0);
    repeat (40) @(negedge clk);
    chk("R3 opcode 0 halts", {nfetch[31:0], err}, {32'd1, 1'b1});

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule